// File: doc/BRIEF.md
# Zero-Cross Gated Stereo Volume Updater

This block is the control logic for a stereo pair of gain stages. Software writes a 9-bit control word for the left or the right channel. The word carries a volume code, a mute flag and a zero-cross enable. Each write lands in a staging (shadow) register, and the gain stage keeps its current setting. A 1 in the update bit of a write to either channel commits the staged words of both channels at once. This lets the two sides of a stereo pair change together.

When zero-cross gating is off, a channel takes its staged setting one clock after the update write. When gating is on, the channel waits until its own audio signal changes sign. The sign is reported through a shared sample strobe that carries one sign bit per channel. If no crossing arrives, a slow free-running tick forces the change on the second tick after the request. The forced change therefore lands between one and two tick periods after the update write. The gain stage itself lies outside this block, which only presents the active volume and mute for each channel.

Top module: `zcv_volume_updater`

## Requirements
- R1: While `rst_n` is low, and after it is released, both channels show volume code 16 (binary 010000, 0 dB) with mute 0. Staged words reset to the same values, with zero-cross enable 0 and nothing pending.
- R2: A write word places the volume code in bits 5:0, mute in bit 6, zero-cross enable in bit 7 and update in bit 8. A write whose bit 8 is 0 changes only the staged word, and the active outputs stay as they were.
- R3: A write with bit 8 set, on either channel, requests a commit for both channels. Each channel then applies its own staged volume and mute together.
- R4: The update bit is not stored. Writes with bit 8 clear that follow a completed commit start no further commit.
- R5: A channel whose staged zero-cross enable is 0 applies its staged setting at the clock edge that follows the edge that captured the update write.
- R6: A pending channel whose staged zero-cross enable is 1 applies at the edge where `smp_stb` is high and its sign bit (1 = negative) differs from the sign captured at the previous strobe. The first strobe after reset is never a crossing. Each channel is gated only by its own sign.
- R7: A pending channel with no crossing is forced on the second `tick` after the update write. A tick in the same cycle as the update write is not counted.
- R8: An update write while a commit is still pending restarts the request and the timeout. In a cycle with an update write, no channel applies.
- R9: A channel applies the staged word as it stands at the moment of application, including writes made without bit 8 while the commit was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_left | input | 1 | Write strobe for the left channel word |
| wr_right | input | 1 | Write strobe for the right channel word |
| wr_data | input | 9 | Write word: update, zero-cross enable, mute, volume |
| smp_stb | input | 1 | Sample strobe, qualifies both sign inputs |
| sign_left | input | 1 | Left sample sign (1 = negative) |
| sign_right | input | 1 | Right sample sign (1 = negative) |
| tick | input | 1 | One-cycle pulse of the free-running timeout tick |
| vol_left | output | 6 | Active left volume code |
| mute_left | output | 1 | Active left mute |
| vol_right | output | 6 | Active right volume code |
| mute_right | output | 1 | Active right mute |

## Verification
The bench targets several cases that are easy to get wrong. A write without the update bit must not move the outputs, and a latched update bit would make later plain writes commit. A commit requested from one side must also move the other side, and a design that commits only the written channel leaves the stereo pair out of step. Under zero-cross gating, one channel's crossing must not release the other, and the first sample after reset must not count as a crossing. The timeout must fire on the second tick, not the first, and an update write must restart it. A design that keeps old tick history would apply one period early. Long random runs with mixed strobes are compared against a cycle model held in the bench.

// File: rtl/zcv_pkg.sv
// Shared constants and types for the zero-cross gated volume updater.
// Assumes a fixed 9-bit control word layout decoded by software.
package zcv_pkg;
    localparam int unsigned VOL_W    = 6;
    localparam int unsigned WORD_W   = VOL_W + 3;
    localparam int unsigned MUTE_BIT = VOL_W;
    localparam int unsigned ZCE_BIT  = VOL_W + 1;
    localparam int unsigned UPD_BIT  = VOL_W + 2;
    localparam int unsigned NCH      = 2;

    // Staged or active per-channel settings
    typedef struct packed {
        logic             zce;
        logic             mute;
        logic [VOL_W-1:0] vol;
    } chan_cfg_t;
endpackage

// File: rtl/zcv_shadow.sv
// Staging register for one channel's control word.
// Captures zero-cross enable, mute and volume on each write strobe.
// The update bit is deliberately not stored here.
module zcv_shadow
    import zcv_pkg::*;
#(
    parameter int unsigned VOL_RESET = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output chan_cfg_t         staged
);
    // Capture the staged word on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged.zce  <= 1'b0;
            staged.mute <= 1'b0;
            staged.vol  <= VOL_W'(VOL_RESET);
        end else if (wr_en) begin
            staged.zce  <= wr_word[ZCE_BIT];
            staged.mute <= wr_word[MUTE_BIT];
            staged.vol  <= wr_word[VOL_W-1:0];
        end
    end
endmodule

// File: rtl/zcv_zero_detect.sv
// Sign-change detector for one channel.
// Assumes sign samples qualified by a strobe; the first strobe after
// reset only primes the history and never reports a crossing.
module zcv_zero_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_stb,
    input  logic smp_sign,
    output logic zc_event
);
    logic prev_sign;
    logic primed;

    // A crossing is a strobed sign differing from the stored sign
    always_comb zc_event = smp_stb && primed && (smp_sign != prev_sign);

    // Keep the sign of the last strobed sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sign <= 1'b0;
            primed    <= 1'b0;
        end else if (smp_stb) begin
            prev_sign <= smp_sign;
            primed    <= 1'b1;
        end
    end
endmodule

// File: rtl/zcv_timeout.sv
// Tick counter for the forced update.
// Restarted by every update request; fires on tick number TMO_TICKS
// after the restart. A tick coinciding with a restart is not counted.
module zcv_timeout #(
    parameter int unsigned TMO_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic fire
);
    localparam int unsigned CNT_W = (TMO_TICKS > 1) ? $clog2(TMO_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    // Fire on the final tick of the window
    always_comb fire = tick && !restart && (cnt == LAST);

    // Count ticks since the last request, saturating at the final one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/zcv_apply.sv
// Active setting and pending flag for one channel.
// Applies the staged word once a request is pending and either gating
// is off, a zero crossing is seen or the timeout fires. A new request
// in the same cycle takes precedence over applying.
module zcv_apply
    import zcv_pkg::*;
#(
    parameter int unsigned VOL_RESET = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  chan_cfg_t        staged,
    input  logic             zc_event,
    input  logic             tmo_fire,
    output logic [VOL_W-1:0] act_vol,
    output logic             act_mute,
    output logic             pending
);
    logic go;

    // Decide whether a pending channel applies in this cycle
    always_comb go = pending && !req && (!staged.zce || zc_event || tmo_fire);

    // Track the outstanding request
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (req)  pending <= 1'b1;
        else if (go)   pending <= 1'b0;
    end

    // Move the staged volume and mute to the active outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_vol  <= VOL_W'(VOL_RESET);
            act_mute <= 1'b0;
        end else if (go) begin
            act_vol  <= staged.vol;
            act_mute <= staged.mute;
        end
    end
endmodule

// File: rtl/zcv_volume_updater.sv
// Double-buffered stereo volume updater with zero-cross gating.
// Assumes write strobes, sample strobes and tick are synchronous
// single-cycle pulses in the clk domain.
module zcv_volume_updater
    import zcv_pkg::*;
#(
    parameter int unsigned VOL_RESET = 16,
    parameter int unsigned TMO_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_left,
    input  logic              wr_right,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              smp_stb,
    input  logic              sign_left,
    input  logic              sign_right,
    input  logic              tick,
    output logic [VOL_W-1:0]  vol_left,
    output logic              mute_left,
    output logic [VOL_W-1:0]  vol_right,
    output logic              mute_right
);
    logic [NCH-1:0]   wr_ch;
    logic [NCH-1:0]   sign_ch;
    logic [NCH-1:0]   zc_ev;
    logic [NCH-1:0]   pend_q;
    logic [NCH-1:0]   mute_ch;
    logic [VOL_W-1:0] vol_ch [NCH];
    chan_cfg_t        staged [NCH];
    logic             upd_req;
    logic             tmo_fire;

    // Gather per-channel inputs into indexed vectors
    always_comb begin
        wr_ch   = {wr_right, wr_left};
        sign_ch = {sign_right, sign_left};
    end

    // An update bit on either channel's write requests a joint commit
    always_comb upd_req = (wr_left || wr_right) && wr_data[UPD_BIT];

    zcv_timeout #(.TMO_TICKS(TMO_TICKS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (upd_req),
        .tick    (tick),
        .fire    (tmo_fire)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        zcv_shadow #(.VOL_RESET(VOL_RESET)) u_shadow (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_ch[ch]),
            .wr_word (wr_data),
            .staged  (staged[ch])
        );

        zcv_zero_detect u_zc (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_stb  (smp_stb),
            .smp_sign (sign_ch[ch]),
            .zc_event (zc_ev[ch])
        );

        zcv_apply #(.VOL_RESET(VOL_RESET)) u_apply (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (upd_req),
            .staged   (staged[ch]),
            .zc_event (zc_ev[ch]),
            .tmo_fire (tmo_fire),
            .act_vol  (vol_ch[ch]),
            .act_mute (mute_ch[ch]),
            .pending  (pend_q[ch])
        );
    end

    // Drive the named outputs from the channel arrays
    always_comb begin
        vol_left   = vol_ch[0];
        mute_left  = mute_ch[0];
        vol_right  = vol_ch[1];
        mute_right = mute_ch[1];
    end
endmodule

// File: rtl/zcv_checker.sv
// Property checker for zcv_volume_updater, attached by bind.
module zcv_checker
    import zcv_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_left,
    input logic              wr_right,
    input logic [WORD_W-1:0] wr_data,
    input logic              upd_req,
    input logic              tmo_fire,
    input logic [NCH-1:0]    pend_q,
    input logic [NCH-1:0]    zc_ev,
    input logic              zce_left,
    input logic [VOL_W-1:0]  vol_left,
    input logic              mute_left,
    input logic [VOL_W-1:0]  vol_right,
    input logic              mute_right
);
    // R2
    left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0] |=> $stable(vol_left) && $stable(mute_left));

    // R2
    right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[1] |=> $stable(vol_right) && $stable(mute_right));

    // R4
    no_latched_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) && !upd_req |=> pend_q == '0);

    // R5
    direct_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_left && wr_data[UPD_BIT] && !wr_data[ZCE_BIT]) ##1 !upd_req
        |=> vol_left == $past(wr_data[VOL_W-1:0], 2));

    // R6
    crossing_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[0] && zce_left && zc_ev[0] && !upd_req |=> !pend_q[0]);

    // R7
    timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[1] && tmo_fire |=> !pend_q[1]);

    // R8
    request_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |=> pend_q == '1);
endmodule

bind zcv_volume_updater zcv_checker i_zcv_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_left    (wr_left),
    .wr_right   (wr_right),
    .wr_data    (wr_data),
    .upd_req    (upd_req),
    .tmo_fire   (tmo_fire),
    .pend_q     (pend_q),
    .zc_ev      (zc_ev),
    .zce_left   (staged[0].zce),
    .vol_left   (vol_left),
    .mute_left  (mute_left),
    .vol_right  (vol_right),
    .mute_right (mute_right)
);

// File: tb/test_zcv_volume_updater.sv
// Bench for zcv_volume_updater: directed corner cases, then seeded
// random stimulus compared against a cycle model of the requirements.
module test_zcv_volume_updater;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_left = 1'b0, wr_right = 1'b0;
    logic [8:0] wr_data = '0;
    logic       smp_stb = 1'b0, sign_left = 1'b0, sign_right = 1'b0, tick = 1'b0;
    logic [5:0] vol_left, vol_right;
    logic       mute_left, mute_right;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zcv_volume_updater i_zcv_volume_updater (
        .clk(clk), .rst_n(rst_n), .wr_left(wr_left), .wr_right(wr_right),
        .wr_data(wr_data), .smp_stb(smp_stb), .sign_left(sign_left),
        .sign_right(sign_right), .tick(tick), .vol_left(vol_left),
        .mute_left(mute_left), .vol_right(vol_right), .mute_right(mute_right)
    );

    // Cycle model built from the requirements
    logic [5:0] m_svol [2];
    logic       m_smute [2], m_szce [2], m_pend [2], m_prev [2];
    logic [5:0] m_avol [2];
    logic       m_amute [2];
    logic       m_primed;
    int         m_cnt;

    always @(posedge clk) begin
        logic upd, fire, go;
        logic [1:0] wr, sg;
        wr = {wr_right, wr_left};
        sg = {sign_right, sign_left};
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_svol[c] = 6'd16; m_smute[c] = 0; m_szce[c] = 0; m_pend[c] = 0;
                m_prev[c] = 0; m_avol[c] = 6'd16; m_amute[c] = 0;
            end
            m_primed = 0; m_cnt = 0;
        end else begin
            upd  = (wr_left || wr_right) && wr_data[8];
            fire = tick && !upd && (m_cnt == TMO - 1);
            for (int c = 0; c < 2; c++) begin
                go = m_pend[c] && !upd &&
                     (!m_szce[c] || (smp_stb && m_primed && sg[c] != m_prev[c]) || fire);
                if (go) begin
                    m_avol[c] = m_svol[c]; m_amute[c] = m_smute[c];
                end
                m_pend[c] = upd ? 1'b1 : (go ? 1'b0 : m_pend[c]);
                if (wr[c]) begin
                    m_svol[c] = wr_data[5:0]; m_smute[c] = wr_data[6]; m_szce[c] = wr_data[7];
                end
                if (smp_stb) m_prev[c] = sg[c];
            end
            if (smp_stb) m_primed = 1;
            if (upd) m_cnt = 0;
            else if (tick && m_cnt != TMO - 1) m_cnt++;
        end
    end

    function automatic logic [8:0] word(input bit upd, zce, mute, input int vol);
        return {upd, zce, mute, vol[5:0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input int vl, ml, vr, mr);
        check({req, " vol_left"}, vol_left, vl);
        check({req, " mute_left"}, mute_left, ml);
        check({req, " vol_right"}, vol_right, vr);
        check({req, " mute_right"}, mute_right, mr);
    endtask

    // Apply one cycle of inputs, then return at the next falling edge
    task automatic drive(input bit wl, wrr, input logic [8:0] d,
                         input bit stb, sl, sr, tk);
        wr_left = wl; wr_right = wrr; wr_data = d;
        smp_stb = stb; sign_left = sl; sign_right = sr; tick = tk;
        @(negedge clk);
        wr_left = 0; wr_right = 0; wr_data = '0; smp_stb = 0; tick = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, '0, 0, sign_left, sign_right, 0);
    endtask

    initial begin
        int seed;
        seed = 20240611;
        void'($urandom(seed));
        @(negedge clk);
        idle(3);
        chk_out("R1 in reset", 16, 0, 16, 0);
        rst_n = 1'b1;
        idle(2);
        chk_out("R1 after reset", 16, 0, 16, 0);

        // R2: staged write without update leaves active unchanged
        drive(1, 0, word(0, 0, 0, 5), 0, 0, 0, 0);
        chk_out("R2 staged only", 16, 0, 16, 0);
        idle(3);
        chk_out("R2 still staged", 16, 0, 16, 0);

        // R3/R5: update on right commits both, one cycle later
        drive(0, 1, word(1, 0, 1, 9), 0, 0, 0, 0);
        chk_out("R5 not before next edge", 16, 0, 16, 0);
        idle(1);
        chk_out("R3 joint commit", 5, 0, 9, 1);

        // R4: update bit not latched
        drive(1, 0, word(0, 0, 0, 33), 0, 0, 0, 0);
        idle(4);
        chk_out("R4 no second commit", 5, 0, 9, 1);

        // R6: zero-cross gating, per channel
        drive(1, 0, word(0, 1, 0, 20), 0, 0, 0, 0);
        drive(0, 1, word(1, 1, 0, 40), 0, 0, 0, 0);
        idle(3);
        chk_out("R6 waits for crossing", 5, 0, 9, 1);
        drive(0, 0, '0, 1, 1, 1, 0);
        chk_out("R6 first strobe is no crossing", 5, 0, 9, 1);
        // R9: staged change during pending is what gets applied
        drive(1, 0, word(0, 1, 1, 21), 0, 1, 1, 0);
        drive(0, 0, '0, 1, 0, 1, 0);
        chk_out("R6 R9 left crossing only", 21, 1, 9, 1);

        // R7: timeout on the second tick
        drive(0, 0, '0, 0, 0, 1, 1);
        chk_out("R7 first tick holds", 21, 1, 9, 1);
        idle(2);
        drive(0, 0, '0, 0, 0, 1, 1);
        chk_out("R7 second tick forces", 21, 1, 40, 0);

        // R8: a new request restarts the timeout
        drive(0, 1, word(1, 1, 0, 50), 0, 0, 1, 0);
        drive(0, 0, '0, 0, 0, 1, 1);
        drive(0, 1, word(1, 1, 0, 51), 0, 0, 1, 1);
        drive(0, 0, '0, 0, 0, 1, 1);
        chk_out("R8 restart holds", 21, 1, 40, 0);
        drive(0, 0, '0, 0, 0, 1, 1);
        chk_out("R8 forced after restart", 21, 1, 51, 0);

        // Random phase against the model (R2..R9)
        for (int i = 0; i < 4000; i++) begin
            bit wl, wrr, stb, tk;
            logic [8:0] d;
            wl  = ($urandom % 6) == 0;
            wrr = ($urandom % 6) == 0;
            d   = 9'($urandom);
            d[8] = ($urandom % 4) == 0;
            stb = ($urandom % 3) == 0;
            tk  = ($urandom % 9) == 0;
            drive(wl, wrr, d, stb, 1'($urandom), 1'($urandom), tk);
            chk_out("R3 R6 R7 R9 random", m_avol[0], m_amute[0], m_avol[1], m_amute[1]);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule